// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Arbiter

The arbiter sits at the decode stage of an in-order, two-wide pipeline. Each cycle it sees the two oldest decoded instructions, the older in slot 0 and the younger in slot 1. Each slot carries a valid bit, a 3-bit group code and, for complex instructions, a 2-bit sub-kind. From these it raises one issue strobe per slot. The strobes are combinational, so they apply to the instructions presented in the same cycle. Only structural rules are applied: each group claims a set of shared issue or execute resources, and two instructions pair only when their claims do not overlap. Complex instructions always issue alone.

Some complex sub-kinds hold the decode stage after they issue. A down-counter is loaded with the hold length for that sub-kind. While it is nonzero, the decode-stall flag is high and nothing issues. Operand dependencies, execution and branch outcome are handled elsewhere.

Group codes: MT=0, EX=1, BR=2, LS=3, FE=4, CO=5, and 6 and 7 are reserved. CO sub-kinds: 0 plain, 1 exception return, 2 far jump or subroutine return, 3 procedure-register load or store.

Top module: `dual_issue_pair_arb`

## Requirements
- R1: At most two instructions issue per cycle. When slot 0 is valid, `issue1` is high only if `issue0` is high in the same cycle.
- R2: A CO instruction (group 5) never issues together with another instruction. If it sits in slot 0, only `issue0` rises.
- R3: These pairs never dual-issue, in either slot order: EX with EX (1,1), EX with BR (1,2) and BR with EX (2,1).
- R4: These pairs never dual-issue: BR with BR (2,2), BR with LS (2,3), LS with BR (3,2) and LS with LS (3,3).
- R5: Two FE instructions (4,4) never dual-issue.
- R6: Both strobes rise for MT (0) paired with any group 0..4 in either order, and for the pairs EX+LS, EX+FE, BR+FE and LS+FE in either order.
- R7: An invalid slot never blocks the other slot. With slot 0 invalid and no hold active, a valid slot 1 issues alone. This includes a CO in slot 1, which then starts its own hold. With slot 1 invalid, `issue1` stays low.
- R8: When a CO instruction issues, the hold length is set by its sub-kind. Sub-kind 1 holds for 5 cycles, sub-kind 2 for 2 cycles and sub-kind 3 for 2 cycles. The hold covers the cycles directly after the issue cycle.
- R9: During a hold, `dec_stall` is high and both strobes are low. Instructions presented during a hold do not issue, and a CO presented during a hold does not restart or lengthen the hold. In the first cycle after the hold ends, `dec_stall` is low and issue resumes.
- R10: A CO of sub-kind 0 issues alone and causes no hold. Reserved group codes 6 and 7 issue alone and cause no hold. The sub-kind of a non-CO instruction is ignored.
- R11: While `rst_n` is low, and in the first cycle after it is released, `dec_stall` is low. Asserting reset during a hold ends the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot0_vld | input | 1 | Older instruction present |
| slot0_grp | input | 3 | Group code of the older instruction |
| slot0_kind | input | 2 | CO sub-kind of the older instruction |
| slot1_vld | input | 1 | Younger instruction present |
| slot1_grp | input | 3 | Group code of the younger instruction |
| slot1_kind | input | 2 | CO sub-kind of the younger instruction |
| issue0 | output | 1 | Older instruction issues this cycle |
| issue1 | output | 1 | Younger instruction issues this cycle |
| dec_stall | output | 1 | Decode held by a complex instruction |

## Verification
Two functions can fall in the same cycle: pairing arbitration of new instructions and the decode hold left by an earlier complex instruction. The bench provokes this by presenting pairable MT pairs, and a fresh exception-return CO, throughout every hold window. It counts the stalled cycles at the ports and checks that the count matches the sub-kind that started the hold, not the one presented during it. In the first free cycle it checks that the waiting instructions issue, and that an exception return waiting there starts a new hold.

// File: rtl/pair_arb_pkg.sv
package pair_arb_pkg;

  localparam int GRP_W  = 3;
  localparam int KIND_W = 2;
  localparam int RES_W  = 4;

  typedef enum logic [GRP_W-1:0] {
    GRP_MT = 3'd0,
    GRP_EX = 3'd1,
    GRP_BR = 3'd2,
    GRP_LS = 3'd3,
    GRP_FE = 3'd4,
    GRP_CO = 3'd5
  } grp_e;

  localparam logic [KIND_W-1:0] KIND_PLAIN = 2'd0;
  localparam logic [KIND_W-1:0] KIND_EXC   = 2'd1;
  localparam logic [KIND_W-1:0] KIND_FAR   = 2'd2;
  localparam logic [KIND_W-1:0] KIND_PR    = 2'd3;

  // shared resource bits claimed in the issue cycle
  localparam int RB_INT  = 0;  // integer execute
  localparam int RB_ADDR = 1;  // branch address calculator
  localparam int RB_LSU  = 2;  // load/store issue port
  localparam int RB_FP0  = 3;  // first floating-point stage

  function automatic logic [RES_W-1:0] res_claim(input logic [GRP_W-1:0] g);
    logic [RES_W-1:0] m;
    m = '0;
    case (g)
      GRP_EX: m[RB_INT] = 1'b1;
      GRP_BR: begin
        m[RB_INT]  = 1'b1;
        m[RB_ADDR] = 1'b1;
        m[RB_LSU]  = 1'b1;
      end
      GRP_LS: m[RB_LSU] = 1'b1;
      GRP_FE: m[RB_FP0] = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction

  // CO and the reserved codes always go alone
  function automatic logic solo_group(input logic [GRP_W-1:0] g);
    return g >= GRP_CO;
  endfunction

  function automatic int hold_cycles(input logic [KIND_W-1:0] k,
                                     input int exc, input int far, input int pr);
    case (k)
      KIND_EXC: return exc;
      KIND_FAR: return far;
      KIND_PR:  return pr;
      default:  return 0;
    endcase
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/slot_classify.sv
module slot_classify
  import pair_arb_pkg::*;
#(
  parameter int LOCK_EXC = 5,
  parameter int LOCK_FAR = 2,
  parameter int LOCK_PR  = 2,
  parameter int CNT_W    = 3
) (
  input  logic              vld,
  input  logic [GRP_W-1:0]  grp,
  input  logic [KIND_W-1:0] kind,
  output logic [RES_W-1:0]  res,
  output logic              solo,
  output logic              lock_req,
  output logic [CNT_W-1:0]  lock_len
);
  int len_i;

  always_comb begin
    res      = res_claim(grp);
    solo     = solo_group(grp);
    len_i    = hold_cycles(kind, LOCK_EXC, LOCK_FAR, LOCK_PR);
    lock_len = CNT_W'(len_i);
    lock_req = vld && (grp == GRP_CO) && (len_i != 0);
  end
endmodule

// File: rtl/pair_rules.sv
module pair_rules
  import pair_arb_pkg::*;
(
  input  logic [RES_W-1:0] res_a,
  input  logic             solo_a,
  input  logic [RES_W-1:0] res_b,
  input  logic             solo_b,
  output logic             pair_ok
);
  logic [RES_W-1:0] overlap;

  always_comb begin
    overlap = res_a & res_b;
    pair_ok = !solo_a && !solo_b && (overlap == '0);
  end
endmodule

// File: rtl/lock_ctr.sv
module lock_ctr #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  output logic [CNT_W-1:0] cnt,
  output logic             active
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_len;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/dual_issue_pair_arb.sv
module dual_issue_pair_arb
  import pair_arb_pkg::*;
#(
  parameter int LOCK_EXC = 5,
  parameter int LOCK_FAR = 2,
  parameter int LOCK_PR  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot0_vld,
  input  logic [GRP_W-1:0]  slot0_grp,
  input  logic [KIND_W-1:0] slot0_kind,
  input  logic              slot1_vld,
  input  logic [GRP_W-1:0]  slot1_grp,
  input  logic [KIND_W-1:0] slot1_kind,
  output logic              issue0,
  output logic              issue1,
  output logic              dec_stall
);
  localparam int NSLOT    = 2;
  localparam int LOCK_MAX = max3(LOCK_EXC, LOCK_FAR, LOCK_PR);
  localparam int CNT_W    = $clog2(LOCK_MAX + 1);

  logic [NSLOT-1:0]             vld;
  logic [NSLOT-1:0][GRP_W-1:0]  grp;
  logic [NSLOT-1:0][KIND_W-1:0] kind;
  logic [NSLOT-1:0][RES_W-1:0]  res;
  logic [NSLOT-1:0]             solo;
  logic [NSLOT-1:0]             lock_req;
  logic [NSLOT-1:0][CNT_W-1:0]  lock_len;

  // named internal events for the checker
  logic             pair_ok;
  logic             lock_active;
  logic             lock_load;
  logic [CNT_W-1:0] lock_sel_len;
  logic [CNT_W-1:0] lock_cnt;

  assign vld  = {slot1_vld, slot0_vld};
  assign grp  = {slot1_grp, slot0_grp};
  assign kind = {slot1_kind, slot0_kind};

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    slot_classify #(
      .LOCK_EXC(LOCK_EXC), .LOCK_FAR(LOCK_FAR), .LOCK_PR(LOCK_PR), .CNT_W(CNT_W)
    ) u_cls (
      .vld     (vld[s]),
      .grp     (grp[s]),
      .kind    (kind[s]),
      .res     (res[s]),
      .solo    (solo[s]),
      .lock_req(lock_req[s]),
      .lock_len(lock_len[s])
    );
  end

  pair_rules u_rules (
    .res_a  (res[0]),
    .solo_a (solo[0]),
    .res_b  (res[1]),
    .solo_b (solo[1]),
    .pair_ok(pair_ok)
  );

  always_comb begin
    issue0 = vld[0] && !lock_active;
    issue1 = vld[1] && !lock_active && (!vld[0] || pair_ok);
    lock_load    = 1'b0;
    lock_sel_len = '0;
    if (issue0 && lock_req[0]) begin
      lock_load    = 1'b1;
      lock_sel_len = lock_len[0];
    end else if (issue1 && lock_req[1]) begin
      lock_load    = 1'b1;
      lock_sel_len = lock_len[1];
    end
  end

  lock_ctr #(.CNT_W(CNT_W)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (lock_load),
    .load_len(lock_sel_len),
    .cnt     (lock_cnt),
    .active  (lock_active)
  );

  assign dec_stall = lock_active;
endmodule

// File: rtl/pair_arb_chk.sv
module pair_arb_chk #(
  parameter int LOCK_EXC = 5,
  parameter int CNT_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slot0_vld,
  input logic [2:0]       slot0_grp,
  input logic [1:0]       slot0_kind,
  input logic             slot1_vld,
  input logic [2:0]       slot1_grp,
  input logic [1:0]       slot1_kind,
  input logic             issue0,
  input logic             issue1,
  input logic             dec_stall,
  input logic             lock_load,
  input logic [CNT_W-1:0] lock_cnt
);
  logic dual;
  assign dual = issue0 && issue1;

  assert_in_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue1 && slot0_vld) |-> issue0);

  assert_co_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dual |-> (slot0_grp != 3'd5 && slot1_grp != 3'd5));

  assert_int_share_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dual |-> !((slot0_grp == 3'd1 || slot0_grp == 3'd2) &&
               (slot1_grp == 3'd1 || slot1_grp == 3'd2) &&
               (slot0_grp == 3'd1 || slot1_grp == 3'd1)));

  assert_br_ls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dual |-> !((slot0_grp == 3'd2 || slot0_grp == 3'd3) &&
               (slot1_grp == 3'd2 || slot1_grp == 3'd3)));

  assert_fe_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dual |-> !(slot0_grp == 3'd4 && slot1_grp == 3'd4));

  assert_slot1_exc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue1 && !slot0_vld && slot1_grp == 3'd5 && slot1_kind == 2'd1)
      |=> (lock_cnt == CNT_W'(LOCK_EXC)));

  assert_exc_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue0 && slot0_grp == 3'd5 && slot0_kind == 2'd1)
      |=> (lock_cnt == CNT_W'(LOCK_EXC)));

  assert_load_on_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_load |-> (issue0 || issue1));

  assert_hold_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stall |-> (!issue0 && !issue1));

  assert_countdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_cnt != '0) |=> (lock_cnt == $past(lock_cnt) - 1'b1));

  assert_plain_co_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue0 && slot0_grp == 3'd5 && slot0_kind == 2'd0) |=> !dec_stall);
endmodule

bind dual_issue_pair_arb pair_arb_chk #(.LOCK_EXC(LOCK_EXC), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slot0_vld (slot0_vld),
  .slot0_grp (slot0_grp),
  .slot0_kind(slot0_kind),
  .slot1_vld (slot1_vld),
  .slot1_grp (slot1_grp),
  .slot1_kind(slot1_kind),
  .issue0    (issue0),
  .issue1    (issue1),
  .dec_stall (dec_stall),
  .lock_load (lock_load),
  .lock_cnt  (lock_cnt)
);

// File: tb/tb_dual_issue_pair_arb.sv
module tb_dual_issue_pair_arb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s0v = 1'b0, s1v = 1'b0;
  logic [2:0] s0g = 3'd0, s1g = 3'd0;
  logic [1:0] s0k = 2'd0, s1k = 2'd0;
  logic       iss0, iss1, stall;
  int         tests = 0, fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  dual_issue_pair_arb dut (
    .clk(clk), .rst_n(rst_n),
    .slot0_vld(s0v), .slot0_grp(s0g), .slot0_kind(s0k),
    .slot1_vld(s1v), .slot1_grp(s1g), .slot1_kind(s1k),
    .issue0(iss0), .issue1(iss1), .dec_stall(stall)
  );

  // {req[13:10], v0, g0[2:0], v1, g1[2:0], exp_issue0, exp_issue1}
  localparam int NVEC = 26;
  localparam logic [13:0] VEC [0:NVEC-1] = '{
    {4'd6,  1'b1, 3'd0, 1'b1, 3'd0, 2'b11},  // MT MT
    {4'd6,  1'b1, 3'd0, 1'b1, 3'd1, 2'b11},  // MT EX
    {4'd6,  1'b1, 3'd1, 1'b1, 3'd0, 2'b11},  // EX MT
    {4'd6,  1'b1, 3'd0, 1'b1, 3'd2, 2'b11},  // MT BR
    {4'd6,  1'b1, 3'd3, 1'b1, 3'd0, 2'b11},  // LS MT
    {4'd6,  1'b1, 3'd0, 1'b1, 3'd4, 2'b11},  // MT FE
    {4'd3,  1'b1, 3'd1, 1'b1, 3'd1, 2'b10},  // EX EX
    {4'd3,  1'b1, 3'd1, 1'b1, 3'd2, 2'b10},  // EX BR
    {4'd3,  1'b1, 3'd2, 1'b1, 3'd1, 2'b10},  // BR EX
    {4'd4,  1'b1, 3'd2, 1'b1, 3'd2, 2'b10},  // BR BR
    {4'd4,  1'b1, 3'd2, 1'b1, 3'd3, 2'b10},  // BR LS
    {4'd4,  1'b1, 3'd3, 1'b1, 3'd2, 2'b10},  // LS BR
    {4'd4,  1'b1, 3'd3, 1'b1, 3'd3, 2'b10},  // LS LS
    {4'd5,  1'b1, 3'd4, 1'b1, 3'd4, 2'b10},  // FE FE
    {4'd6,  1'b1, 3'd1, 1'b1, 3'd3, 2'b11},  // EX LS
    {4'd6,  1'b1, 3'd3, 1'b1, 3'd4, 2'b11},  // LS FE
    {4'd6,  1'b1, 3'd2, 1'b1, 3'd4, 2'b11},  // BR FE
    {4'd6,  1'b1, 3'd4, 1'b1, 3'd1, 2'b11},  // FE EX
    {4'd2,  1'b1, 3'd0, 1'b1, 3'd5, 2'b10},  // MT CO
    {4'd2,  1'b1, 3'd5, 1'b1, 3'd0, 2'b10},  // CO MT
    {4'd7,  1'b0, 3'd1, 1'b1, 3'd1, 2'b01},  // empty EX
    {4'd7,  1'b1, 3'd1, 1'b0, 3'd0, 2'b10},  // EX empty
    {4'd7,  1'b0, 3'd0, 1'b0, 3'd0, 2'b00},  // empty empty
    {4'd10, 1'b1, 3'd6, 1'b1, 3'd0, 2'b10},  // reserved MT
    {4'd10, 1'b1, 3'd0, 1'b1, 3'd7, 2'b10},  // MT reserved
    {4'd1,  1'b0, 3'd5, 1'b1, 3'd4, 2'b01}   // empty slot0 never blocks in-order
  };

  function automatic string rname(input logic [3:0] r);
    case (r)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual {stall,iss0,iss1}=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic put(input logic v0, input logic [2:0] g0, input logic [1:0] k0,
                     input logic v1, input logic [2:0] g1, input logic [1:0] k1);
    s0v = v0; s0g = g0; s0k = k0;
    s1v = v1; s1g = g1; s1k = k1;
  endtask

  task automatic idle(input int n);
    put(1'b0, 3'd0, 2'd0, 1'b0, 3'd0, 2'd0);
    repeat (n) @(negedge clk);
  endtask

  // issue a CO of the given kind, then count stalled cycles while pairable
  // MT pairs (or a fresh exception return) wait at decode
  task automatic hold_test(input string tag, input bit in_s1, input logic [1:0] kind,
                           input int n, input bit wait_co);
    @(negedge clk);
    if (in_s1) put(1'b0, 3'd0, 2'd0, 1'b1, 3'd5, kind);
    else       put(1'b1, 3'd5, kind, 1'b1, 3'd0, 2'd0);
    #1 chk(tag, {stall, iss0, iss1}, in_s1 ? 3'b001 : 3'b010);
    @(negedge clk);
    if (wait_co) put(1'b1, 3'd5, 2'd1, 1'b1, 3'd0, 2'd0);
    else         put(1'b1, 3'd0, 2'd0, 1'b1, 3'd0, 2'd0);
    for (int i = 0; i < n; i++) begin
      #1 chk(tag, {stall, iss0, iss1}, 3'b100);
      @(negedge clk);
    end
    #1 chk(tag, {stall, iss0, iss1}, wait_co ? 3'b010 : 3'b011);
    idle(8);
  endtask

  initial begin
    put(1'b1, 3'd0, 2'd0, 1'b1, 3'd0, 2'd0);
    #2 chk("R11 in reset", {stall, iss0, iss1}, 3'b011);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk("R11 after release", {stall, iss0, iss1}, 3'b011);

    // pairing table, no hold in play
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      put(VEC[i][9], VEC[i][8:6], 2'd0, VEC[i][5], VEC[i][4:2], 2'd0);
      #1 chk(rname(VEC[i][13:10]), {stall, iss0, iss1}, {1'b0, VEC[i][1:0]});
    end

    // R10: sub-kind on non-CO groups ignored, plain CO leaves no hold
    @(negedge clk);
    put(1'b1, 3'd1, 2'd1, 1'b1, 3'd3, 2'd1);
    #1 chk("R10 kind on EX/LS", {stall, iss0, iss1}, 3'b011);
    @(negedge clk);
    #1 chk("R10 kind on EX/LS next", {stall, iss0, iss1}, 3'b011);
    @(negedge clk);
    put(1'b1, 3'd5, 2'd0, 1'b1, 3'd0, 2'd0);
    #1 chk("R10 plain CO", {stall, iss0, iss1}, 3'b010);
    @(negedge clk);
    put(1'b1, 3'd0, 2'd0, 1'b1, 3'd0, 2'd0);
    #1 chk("R10 no hold after plain CO", {stall, iss0, iss1}, 3'b011);
    @(negedge clk);
    put(1'b1, 3'd6, 2'd1, 1'b1, 3'd0, 2'd0);
    #1 chk("R10 reserved alone", {stall, iss0, iss1}, 3'b010);
    @(negedge clk);
    put(1'b1, 3'd0, 2'd0, 1'b1, 3'd0, 2'd0);
    #1 chk("R10 no hold after reserved", {stall, iss0, iss1}, 3'b011);
    idle(2);

    // decode holds per sub-kind
    hold_test("R8 exc return 5", 1'b0, 2'd1, 5, 1'b0);
    hold_test("R8 far jump 2",   1'b0, 2'd2, 2, 1'b0);
    hold_test("R8 pr access 2",  1'b0, 2'd3, 2, 1'b0);
    hold_test("R7 slot1 exc 5",  1'b1, 2'd1, 5, 1'b0);
    hold_test("R9 co during far hold", 1'b0, 2'd2, 2, 1'b1);
    hold_test("R9 co during exc hold", 1'b0, 2'd1, 5, 1'b1);

    // R11: reset in the middle of a hold
    @(negedge clk);
    put(1'b1, 3'd5, 2'd1, 1'b0, 3'd0, 2'd0);
    @(negedge clk);
    put(1'b1, 3'd0, 2'd0, 1'b1, 3'd0, 2'd0);
    #1 chk("R11 hold started", {stall, iss0, iss1}, 3'b100);
    rst_n = 1'b0;
    #1 chk("R11 reset clears hold", {stall, iss0, iss1}, 3'b011);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk("R11 after reset release", {stall, iss0, iss1}, 3'b011);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule